// File: doc/BRIEF.md
# Byte Lane Parity Generator and Checker

This block sits beside a 32-bit processor data bus that carries one parity line per byte. During a write cycle it produces even parity for each outgoing byte and marks the clocks in which those parity lines should be driven: from the second clock of the cycle up to and including the clock in which ready is returned. During a read cycle it captures the returned data, parity and lane qualifiers on the ready clock. In the clock that follows, it drives a one-clock, active-low parity status.

Only lanes that are both enabled and inside the active bus width take part in the read check. A narrow 8-bit device covers lane 0. A 16-bit device covers lanes 0 and 1. The read data reaches the requester unchanged, whatever the parity result. A bus cycle begins with a one-clock start strobe. The read/write flag is sampled with that strobe, and the cycle ends on the first ready seen after its first clock.

Top module: `bus_parity_unit`

## Requirements
- R1: For every byte lane i (data bits 8i+7 down to 8i), wr_par[i] is the XOR of that byte's bits, so each byte together with its parity bit holds an even number of ones.
- R2: wr_par_oe is high in every clock of a write cycle after the start clock, through the clock that carries ready, and low in all other clocks.
- R3: When ready ends a read cycle, perr_n is low in the next clock if any checked lane has rd_par[i] different from the XOR of its byte, and high in that clock otherwise.
- R4: A lane whose byte_en[i] is 0 in the ready clock is not checked.
- R5: The bus width is sampled in the ready clock. With size8=1, only lane 0 is checked. With size8=0 and size16=1, lanes 0 and 1 are checked. With both at 0, all four lanes are checked. size8 takes priority over size16.
- R6: perr_n is high in every clock other than the single clock that follows a read cycle's ready, so an error shows as a pulse one clock long.
- R7: req_data always equals rd_data, whatever the parity result.
- R8: ready is ignored while no cycle is open and in the clock that carries cyc_start. cyc_start is ignored while a cycle is open.
- R9: During and directly after reset, no cycle is open, wr_par_oe is 0 and perr_n is 1.
- R10: The read check uses only the data, parity, enables and width present in the ready clock. Changes to these in the following clock do not alter the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | One-clock strobe in the first clock of a bus cycle |
| is_write | input | 1 | 1 for a write cycle, sampled with cyc_start |
| ready | input | 1 | Cycle completion strobe |
| byte_en | input | 4 | Active-high byte lane enables |
| size8 | input | 1 | Device is 8 bits wide |
| size16 | input | 1 | Device is 16 bits wide |
| wr_data | input | 32 | Outgoing write data |
| wr_par | output | 4 | Even parity, one bit per write data byte |
| wr_par_oe | output | 1 | Parity lines should be driven |
| rd_data | input | 32 | Returned read data |
| rd_par | input | 4 | Returned parity, one bit per byte |
| req_data | output | 32 | Read data passed to the requester |
| perr_n | output | 1 | Parity status, low for an error |

## Verification
The bench aims bad parity at one lane at a time, with that lane inside and outside the byte enables and the 8-bit and 16-bit widths. A design that ignores the mask would pulse on masked lanes, and one that masks the wrong lanes would miss real errors. It returns ready while the bus is idle and in the start clock, where a design that counts those as completions would produce a stray status pulse or end a write early. It scrambles the bus in the clock after ready, which exposes a checker that samples too late, and it runs back-to-back cycles to catch a status that lasts more than one clock.

// File: rtl/bpar_pkg.sv
package bpar_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic {
    CYC_IDLE = 1'b0,
    CYC_DATA = 1'b1
  } cyc_state_e;
endpackage

// File: rtl/bpar_lane.sv
module bpar_lane #(
  parameter int unsigned W = bpar_pkg::LANE_W
) (
  input  logic [W-1:0] lane_bits,
  output logic         even_bit
);
  always_comb begin
    even_bit = 1'b0;
    for (int unsigned k = 0; k < W; k++) begin
      even_bit = even_bit ^ lane_bits[k];
    end
  end
endmodule

// File: rtl/bpar_cycle_tracker.sv
module bpar_cycle_tracker
  import bpar_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic is_write,
  input  logic ready,
  output logic data_phase,
  output logic cyc_is_wr,
  output logic rd_done
);
  cyc_state_e state_q, state_d;
  logic       wr_q, wr_d, wr_en;

  always_comb begin
    state_d = state_q;
    wr_d    = wr_q;
    wr_en   = 1'b0;
    unique case (state_q)
      CYC_IDLE: begin
        if (cyc_start) begin
          state_d = CYC_DATA;
          wr_d    = is_write;
          wr_en   = 1'b1;
        end
      end
      CYC_DATA: begin
        if (ready) begin
          state_d = CYC_IDLE;
        end
      end
      default: state_d = CYC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CYC_IDLE;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (wr_en) begin
        wr_q <= wr_d;
      end
    end
  end

  assign data_phase = (state_q == CYC_DATA);
  assign cyc_is_wr  = wr_q;
  assign rd_done    = data_phase && ready && !wr_q;
endmodule

// File: rtl/bpar_lane_mask.sv
module bpar_lane_mask #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = bpar_pkg::LANE_W
) (
  input  logic [LANES-1:0] byte_en,
  input  logic             size8,
  input  logic             size16,
  output logic [LANES-1:0] lane_mask
);
  localparam int unsigned L8  = (8  + LANE_W - 1) / LANE_W;
  localparam int unsigned L16 = (16 + LANE_W - 1) / LANE_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic in8, in16, in_width;
    assign in8  = (i < L8);
    assign in16 = (i < L16);
    always_comb begin
      if (size8) begin
        in_width = in8;
      end else if (size16) begin
        in_width = in16;
      end else begin
        in_width = 1'b1;
      end
    end
    assign lane_mask[i] = byte_en[i] && in_width;
  end
endmodule

// File: rtl/bpar_read_check.sv
module bpar_read_check #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = bpar_pkg::LANE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     capture,
  input  logic [DATA_W-1:0]        rd_data,
  input  logic [DATA_W/LANE_W-1:0] rd_par,
  input  logic [DATA_W/LANE_W-1:0] lane_mask,
  output logic                     perr_n
);
  localparam int unsigned LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] cap_data_q;
  logic [LANES-1:0]  cap_par_q, cap_mask_q, calc_par, mismatch;
  logic              cap_vld_q, cap_vld_d;

  assign cap_vld_d = capture;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vld_q <= 1'b0;
    end else begin
      cap_vld_q <= cap_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (capture) begin
      cap_data_q <= rd_data;
      cap_par_q  <= rd_par;
      cap_mask_q <= lane_mask;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    bpar_lane #(.W(LANE_W)) u_lane (
      .lane_bits (cap_data_q[i*LANE_W +: LANE_W]),
      .even_bit  (calc_par[i])
    );
    assign mismatch[i] = (calc_par[i] != cap_par_q[i]) && cap_mask_q[i];
  end

  assign perr_n = !(cap_vld_q && (|mismatch));
endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = bpar_pkg::LANE_W,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic              is_write,
  input  logic              ready,
  input  logic [LANES-1:0]  byte_en,
  input  logic              size8,
  input  logic              size16,
  input  logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  wr_par,
  output logic              wr_par_oe,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [LANES-1:0]  rd_par,
  output logic [DATA_W-1:0] req_data,
  output logic              perr_n
);
  logic             data_phase, cyc_is_wr, rd_done;
  logic [LANES-1:0] lane_mask;

  bpar_cycle_tracker u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_start  (cyc_start),
    .is_write   (is_write),
    .ready      (ready),
    .data_phase (data_phase),
    .cyc_is_wr  (cyc_is_wr),
    .rd_done    (rd_done)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_wr
    bpar_lane #(.W(LANE_W)) u_lane (
      .lane_bits (wr_data[i*LANE_W +: LANE_W]),
      .even_bit  (wr_par[i])
    );
  end

  assign wr_par_oe = data_phase && cyc_is_wr;

  bpar_lane_mask #(.LANES(LANES), .LANE_W(LANE_W)) u_mask (
    .byte_en   (byte_en),
    .size8     (size8),
    .size16    (size16),
    .lane_mask (lane_mask)
  );

  bpar_read_check #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (rd_done),
    .rd_data   (rd_data),
    .rd_par    (rd_par),
    .lane_mask (lane_mask),
    .perr_n    (perr_n)
  );

  assign req_data = rd_data;
endmodule

// File: rtl/bus_parity_unit_sva.sv
module bus_parity_unit_sva #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_start,
  input logic              ready,
  input logic [DATA_W-1:0] wr_data,
  input logic [LANES-1:0]  wr_par,
  input logic              wr_par_oe,
  input logic              perr_n
);
  p_par_even_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_par_oe |-> ((^{wr_data, wr_par}) == 1'b0));

  p_oe_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_par_oe) |-> $past(cyc_start));

  p_oe_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_par_oe) |-> $past(ready));

  p_err_after_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> $past(ready));

  p_err_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |=> perr_n);
endmodule

bind bus_parity_unit bus_parity_unit_sva #(.DATA_W(DATA_W), .LANES(LANES)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_start (cyc_start),
  .ready     (ready),
  .wr_data   (wr_data),
  .wr_par    (wr_par),
  .wr_par_oe (wr_par_oe),
  .perr_n    (perr_n)
);

// File: tb/sim_bus_parity_unit.sv
module sim_bus_parity_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk, rst_n, cyc_start, is_write, ready, size8, size16;
  logic [3:0]  byte_en, wr_par, rd_par;
  logic [31:0] wr_data, rd_data, req_data;
  logic        wr_par_oe, perr_n;

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;
  string       scen = "R6";

  bus_parity_unit u0 (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .is_write(is_write),
    .ready(ready), .byte_en(byte_en), .size8(size8), .size16(size16),
    .wr_data(wr_data), .wr_par(wr_par), .wr_par_oe(wr_par_oe),
    .rd_data(rd_data), .rd_par(rd_par), .req_data(req_data), .perr_n(perr_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] good_par(input logic [31:0] d);
    logic [3:0] p;
    for (int b = 0; b < 4; b++) begin
      int ones = 0;
      for (int k = 0; k < 8; k++) ones += d[b*8+k];
      p[b] = (ones % 2 == 1);
    end
    return p;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // behavioural reference state
  bit m_open, m_wr, m_chk, m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_open = 0; m_wr = 0; m_chk = 0; m_err = 0;
    end else begin
      m_chk = 0;
      if (m_open) begin
        if (ready) begin
          if (!m_wr) begin
            logic [3:0] gp;
            m_chk = 1;
            m_err = 0;
            gp = good_par(rd_data);
            for (int i = 0; i < 4; i++) begin
              bit inw;
              inw = size8 ? (i == 0) : (size16 ? (i < 2) : 1'b1);
              if (byte_en[i] && inw && (gp[i] != rd_par[i])) m_err = 1;
            end
          end
          m_open = 0;
        end
      end else if (cyc_start) begin
        m_open = 1;
        m_wr = is_write;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(wr_par == good_par(wr_data), "R1", {28'd0, wr_par}, {28'd0, good_par(wr_data)});
      check(wr_par_oe == (m_open && m_wr), "R2", {31'd0, wr_par_oe}, {31'd0, m_open && m_wr});
      check(perr_n == !(m_chk && m_err), scen, {31'd0, perr_n}, {31'd0, !(m_chk && m_err)});
      check(req_data == rd_data, "R7", req_data, rd_data);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rd_cycle(input logic [31:0] d, input logic [3:0] p, input logic [3:0] be,
                          input logic s8, input logic s16, input bit scramble, input int waits);
    cyc_start = 1; is_write = 0; ready = 0;
    tick();
    cyc_start = 0; rd_data = d; rd_par = p; byte_en = be; size8 = s8; size16 = s16;
    repeat (waits) tick();
    ready = 1;
    tick();
    ready = 0;
    if (scramble) begin
      rd_data = ~d; rd_par = ~p; byte_en = 4'hF; size8 = 0; size16 = 0;
    end
    tick();
  endtask

  task automatic wr_cycle(input logic [31:0] d, input int waits);
    cyc_start = 1; is_write = 1; ready = 0; wr_data = d;
    tick();
    cyc_start = 0;
    repeat (waits) tick();
    ready = 1;
    tick();
    ready = 0;
    tick();
  endtask

  task automatic run_all();
    logic [31:0] d;
    // R9: reset state
    check(wr_par_oe == 1'b0, "R9", {31'd0, wr_par_oe}, 32'd0);
    check(perr_n == 1'b1, "R9", {31'd0, perr_n}, 32'd1);
    rst_n = 1;
    tick();
    check(wr_par_oe == 1'b0, "R9", {31'd0, wr_par_oe}, 32'd0);
    // R1 R2: writes with assorted data
    scen = "R6";
    wr_cycle(32'h0000_0000, 0);
    wr_cycle(32'hFFFF_FFFF, 2);
    wr_cycle(32'h0180_7F01, 1);
    wr_cycle(32'hA5C3_0F96, 3);
    // R3: clean read and one bad lane
    d = 32'h1234_5678;
    scen = "R3"; rd_cycle(d, good_par(d), 4'hF, 0, 0, 0, 1);
    rd_cycle(d, good_par(d) ^ 4'b0100, 4'hF, 0, 0, 0, 0);
    check(perr_n == 1'b1, "R6", {31'd0, perr_n}, 32'd1);
    // R4: bad lane masked by byte enables
    scen = "R4"; rd_cycle(d, good_par(d) ^ 4'b0100, 4'b1011, 0, 0, 0, 1);
    rd_cycle(d, good_par(d) ^ 4'b1000, 4'b1000, 0, 0, 0, 0);
    // R5: width masks
    scen = "R5";
    rd_cycle(d, good_par(d) ^ 4'b0010, 4'hF, 1, 0, 0, 0);
    rd_cycle(d, good_par(d) ^ 4'b0001, 4'hF, 1, 1, 0, 0);
    rd_cycle(d, good_par(d) ^ 4'b1000, 4'hF, 0, 1, 0, 0);
    rd_cycle(d, good_par(d) ^ 4'b0010, 4'hF, 0, 1, 0, 2);
    // R10: bus scrambled after ready
    scen = "R10";
    rd_cycle(d, good_par(d), 4'hF, 0, 0, 1, 0);
    rd_cycle(d, good_par(d) ^ 4'b0100, 4'b0011, 0, 1, 1, 0);
    // R8: stray ready while idle and in the start clock
    scen = "R8";
    rd_data = d; rd_par = ~good_par(d); byte_en = 4'hF; size8 = 0; size16 = 0;
    ready = 1; tick(); tick();
    cyc_start = 1; is_write = 0; tick();
    cyc_start = 0; ready = 0; tick();
    cyc_start = 1; is_write = 1; tick();
    cyc_start = 0; tick();
    ready = 1; tick();
    ready = 0; tick(); tick();
    // R7: requester data unaffected by bad parity
    rd_data = 32'hDEAD_BEEF; rd_par = ~good_par(32'hDEAD_BEEF); #1;
    check(req_data == 32'hDEAD_BEEF, "R7", req_data, 32'hDEAD_BEEF);
    // R6: back-to-back read cycles
    scen = "R6";
    for (int n = 0; n < 6; n++) begin
      d = 32'h9E37_79B9 * (n + 1);
      rd_cycle(d, good_par(d) ^ 4'(n % 3), 4'hF, 0, 0, 0, n % 2);
    end
    tick(); tick();
  endtask

  initial begin
    rst_n = 0; cyc_start = 0; is_write = 0; ready = 0; byte_en = 4'h0;
    size8 = 0; size16 = 0; wr_data = '0; rd_data = '0; rd_par = '0;
    #(CLK_PERIOD * 3 + 1);
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule